// File: doc/BRIEF.md
# Dot Start Governor

This block decides when a dot cycle for character readout may begin on a display beam that is shared with the waveform sweeps. It watches a display priority, the sweep gate and the handshake lines of a display sequencer. From these it issues an active-low start pulse to the dot cycle generator, and raises a readout request towards the sequencer when it needs the beam.

Priorities 1 and 2 use the low path. They take a dot during holdoff, when the sweep gate rises while the dot cycle generator is at rest. While the sequencer reports readout active, they start a new dot each time the generator returns to rest. Priorities 3 and 4 use the handshake path. They raise a readout request that also starts a dot, and they hold that request until the dot cycle's get-dot pulse clears it, so each request yields exactly one dot. The handshake path is also used at priority 2 or higher when no sweeps are present, and at any nonzero priority in interfere mode. The sweep gate and readout-active inputs are asynchronous and pass through two synchronizer flip-flops each.

Top module: `dot_start_gov`

## Requirements
- R1: After reset, `start_dot_n` is 1 and `ro_req` is 0.
- R2: With `prio` equal to 0 or to 5..7, `start_dot_n` never goes low and `ro_req` never rises.
- R3: At `prio` 1 or 2, with `at_rest` high and `ro_active` low, a rising `sweep_gate` drives `start_dot_n` low on the fourth rising clock edge after the input changes. The four stages are two synchronizer stages, edge detection and the request register.
- R4: A rising `sweep_gate` seen while `at_rest` is low is dropped. No start follows, even after `at_rest` returns high.
- R5: Once `start_dot_n` is low, it stays low while `at_rest` is high. It returns to 1 on the first edge that samples `at_rest` low, so the pulse lasts at least one clock.
- R6: At `prio` 1 or 2, while the synchronized `ro_active` is high, every return of `at_rest` to 1 drives `start_dot_n` low on the next edge. Once `ro_active` has fallen and been synchronized, returns to rest start nothing.
- R7: At `prio` 3 or 4, when `ro_req` is 0 and no pulse is active, the first edge that samples `at_rest` high sets `ro_req` to 1 and drives `start_dot_n` low on that same edge. This holds regardless of `sweep_gate`.
- R8: The conditions of R7 also raise `ro_req` at `prio` 2 when `sweeps_present` is 0, and at `prio` 1 or 2 when `interfere` is 1. At `prio` 1 with `interfere` 0, or at `prio` 2 with `sweeps_present` 1 and `interfere` 0, `ro_req` stays 0.
- R9: `get_dot` clears `ro_req` on the next edge, and this clear wins over a new request in the same cycle. Otherwise `ro_req` holds, and while it is 1 no further start is issued on the handshake path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio | input | 3 | Display priority; 1-2 use the low path, 3-4 the handshake path, others are idle |
| sweep_gate | input | 1 | Asynchronous sweep gate; its rising edge marks the start of holdoff |
| ro_active | input | 1 | Asynchronous readout-active acknowledge from the sequencer, high when active |
| sweeps_present | input | 1 | High while any sweep gates are being generated |
| interfere | input | 1 | Interfere-mode flag |
| at_rest | input | 1 | Dot cycle generator is in its rest state |
| get_dot | input | 1 | Get-dot pulse from the dot cycle |
| start_dot_n | output | 1 | Active-low start-dot pulse |
| ro_req | output | 1 | Readout request to the sequencer |

## Verification
Two events can land in the same cycle: the clearing of a pending readout request by `get_dot`, and the return of the generator to rest, which would otherwise raise a fresh request. The bench provokes this by raising `at_rest` and pulsing `get_dot` on the same edge while a high-priority request is held. It then expects `ro_req` to fall with no start pulse, and to rise together with a new start exactly one edge later. A second overlap occurs when the streaming start and a stale sweep request qualify together. The bench judges this by counting one pulse per return to rest.

// File: rtl/dot_start_gov.sv
module dot_start_gov #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] prio,
  input  logic       sweep_gate,
  input  logic       ro_active,
  input  logic       sweeps_present,
  input  logic       interfere,
  input  logic       at_rest,
  input  logic       get_dot,
  output logic       start_dot_n,
  output logic       ro_req
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sg_sync, ra_sync;
  logic         sg_prev, dot_req;
  logic         sg_s, ra_s, sg_rise;
  logic         p_low, p_high, p_ok, pulse;
  logic         low_trig, ro_cond;

  assign sg_s    = sg_sync[TOP];
  assign ra_s    = ra_sync[TOP];
  assign sg_rise = sg_s & ~sg_prev;

  assign p_low  = (prio == 3'd1) || (prio == 3'd2);
  assign p_high = (prio == 3'd3) || (prio == 3'd4);
  assign p_ok   = p_low | p_high;
  assign pulse  = ~start_dot_n;

  assign low_trig = at_rest & p_low & ~pulse & (dot_req | ra_s);
  assign ro_cond  = at_rest & ~ro_req & ~pulse &
                    (p_high | (p_ok & (prio != 3'd1) & ~sweeps_present) | (p_ok & interfere));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_sync <= '0;
      ra_sync <= '0;
      sg_prev <= 1'b0;
    end else begin
      sg_sync <= {sg_sync[TOP-1:0], sweep_gate};
      ra_sync <= {ra_sync[TOP-1:0], ro_active};
      sg_prev <= sg_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dot_req <= 1'b0;
    else        dot_req <= at_rest & p_low & ~pulse & (dot_req | sg_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   start_dot_n <= 1'b1;
    else if (pulse)               start_dot_n <= ~at_rest;
    else if (low_trig | ro_cond)  start_dot_n <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ro_req <= 1'b0;
    else if (get_dot) ro_req <= 1'b0;
    else if (ro_cond) ro_req <= 1'b1;
  end
endmodule

module dot_start_gov_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] prio,
  input logic       at_rest,
  input logic       get_dot,
  input logic       start_dot_n,
  input logic       ro_req
);
  // R2
  no_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_dot_n) |-> $past(prio >= 3'd1 && prio <= 3'd4));
  // R7
  req_at_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ro_req) |-> $past(at_rest));
  // R9
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    get_dot |=> !ro_req);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_req && !get_dot) |=> ro_req);
  // R5
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_dot_n && !at_rest) |=> start_dot_n);
  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_dot_n && at_rest) |=> !start_dot_n);
endmodule

bind dot_start_gov dot_start_gov_chk chk_i (.*);

// File: tb/dot_start_gov_tb_top.sv
module dot_start_gov_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] prio = 3'd0;
  logic sweep_gate = 1'b0, ro_active = 1'b0, sweeps_present = 1'b1;
  logic interfere = 1'b0, at_rest = 1'b0, get_dot = 1'b0;
  logic start_dot_n, ro_req;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  dot_start_gov dut_i (
    .clk(clk), .rst_n(rst_n), .prio(prio), .sweep_gate(sweep_gate),
    .ro_active(ro_active), .sweeps_present(sweeps_present), .interfere(interfere),
    .at_rest(at_rest), .get_dot(get_dot), .start_dot_n(start_dot_n), .ro_req(ro_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nx(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    nx(2);
    chk("R1 start", start_dot_n, 1'b1);
    chk("R1 req", ro_req, 1'b0);
    rst_n = 1'b1;
    nx(1);
    chk("R1 start after release", start_dot_n, 1'b1);
    chk("R1 req after release", ro_req, 1'b0);

    // R2 R7 R8: sweep over priority, sweeps_present and interfere
    for (int p = 0; p < 8; p++)
      for (int sp = 0; sp < 2; sp++)
        for (int it = 0; it < 2; it++) begin
          logic exp;
          at_rest = 1'b0; get_dot = 1'b1;
          prio = 3'(p); sweeps_present = sp[0]; interfere = it[0];
          nx(1); get_dot = 1'b0;
          nx(1);
          chk("R9 cleared", ro_req, 1'b0);
          chk("R5 idle", start_dot_n, 1'b1);
          exp = (p == 3 || p == 4) || (p >= 2 && p <= 4 && sp == 0) ||
                (p >= 1 && p <= 4 && it == 1);
          at_rest = 1'b1;
          nx(1);
          chk(exp ? "R7/R8 request" : "R2/R8 no request", ro_req, exp);
          chk(exp ? "R7 start" : "R2 no start", start_dot_n, ~exp);
        end

    // R9 collision of get_dot and return to rest
    at_rest = 1'b0; get_dot = 1'b1; prio = 3'd3; sweeps_present = 1'b1; interfere = 1'b0;
    nx(1); get_dot = 1'b0; nx(1);
    at_rest = 1'b1; nx(1);
    chk("R7 request", ro_req, 1'b1);
    at_rest = 1'b0; nx(1);
    chk("R5 end", start_dot_n, 1'b1);
    chk("R9 held", ro_req, 1'b1);
    at_rest = 1'b1; nx(1);
    chk("R9 one dot per request", start_dot_n, 1'b1);
    at_rest = 1'b0; nx(1);
    at_rest = 1'b1; get_dot = 1'b1; nx(1);
    chk("R9 clear wins", ro_req, 1'b0);
    chk("R9 no start on clear", start_dot_n, 1'b1);
    get_dot = 1'b0; nx(1);
    chk("R9 new request", ro_req, 1'b1);
    chk("R7 new start", start_dot_n, 1'b0);
    at_rest = 1'b0; get_dot = 1'b1; nx(1); get_dot = 1'b0; nx(1);

    // R3 R5: sweep path at priority 1 and 2
    for (int p = 1; p <= 2; p++) begin
      prio = 3'(p); at_rest = 1'b1;
      nx(2);
      sweep_gate = 1'b1;
      nx(3);
      chk("R3 not yet", start_dot_n, 1'b1);
      nx(1);
      chk("R3 start on fourth edge", start_dot_n, 1'b0);
      nx(2);
      chk("R5 held while at rest", start_dot_n, 1'b0);
      at_rest = 1'b0; nx(1);
      chk("R5 released", start_dot_n, 1'b1);
      chk("R3 no request", ro_req, 1'b0);
      sweep_gate = 1'b0; nx(4);
    end

    // R4: sweep edge while busy
    prio = 3'd1; at_rest = 1'b0;
    sweep_gate = 1'b1; nx(6);
    at_rest = 1'b1;
    for (int i = 0; i < 4; i++) begin
      nx(1);
      chk("R4 edge while busy ignored", start_dot_n, 1'b1);
    end
    sweep_gate = 1'b0; at_rest = 1'b0; nx(4);

    // R6: streaming while readout active
    for (int p = 1; p <= 2; p++) begin
      int pulses;
      pulses = 0;
      prio = 3'(p); at_rest = 1'b0; ro_active = 1'b1;
      nx(3);
      for (int k = 0; k < 5; k++) begin
        at_rest = 1'b1; nx(1);
        chk("R6 start per rest", start_dot_n, 1'b0);
        if (start_dot_n == 1'b0) pulses++;
        at_rest = 1'b0; nx(1);
        chk("R6 pulse ends", start_dot_n, 1'b1);
        nx(2);
      end
      checks++;
      if (pulses != 5) begin
        errors++;
        $display("FAIL R6 pulse count: actual=%0d expected=5", pulses);
      end
      ro_active = 1'b0; nx(3);
      at_rest = 1'b1;
      for (int i = 0; i < 3; i++) begin
        nx(1);
        chk("R6 stops after readout ends", start_dot_n, 1'b1);
      end
      at_rest = 1'b0; nx(2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule